// File: doc/BRIEF.md
# Clocked Synchronous Serial Shifter

An 8-bit synchronous serial transceiver in which one shift register carries both the outgoing and the incoming byte. Software programs the block through a small register port: a data register whose write launches a transfer, a control register, and a divider value. At the end of a transfer the data register holds the byte received. There is no separate transmit buffer, so a new byte can only be loaded once the current transfer has finished.

The transfer clock is either generated inside the block or taken from the clock pin. When generated, it is derived from a prescaled clock-enable input, runs for exactly eight pulses and then rests at a level set by the polarity bit. When taken from the pin, the block shifts on every edge that arrives. The data output drives only while it has something to say. In internal-clock mode it floats between transfers. In external-clock mode it drives a programmable rest level. A one-cycle completion pulse serves as the interrupt request.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the data register reads 0x00, the control register reads 0x00 (internal clock, polarity 0, LSB first, rest level 0, no error), the clock output is high with its enable set, the data output enable is low and the completion pulse is low.
- R2: In internal-clock mode a write to the data register (address 0) while idle starts a transfer of exactly 8 clock pulses. Afterwards the clock rests high when the polarity bit (control bit 1) is 0, and low when it is 1.
- R3: In internal-clock mode every half period of the transfer clock lasts n+1 cycles in which the prescale enable is high, where n is the divider register (address 2, 0x00 to 0xFF).
- R4: With control bit 2 set, bits leave and enter most significant bit first. With it clear, least significant bit first.
- R5: With polarity 0, output data changes on falling clock edges and input data is sampled on rising edges. With polarity 1, the two edges swap.
- R6: At the end of a transfer the data register holds the 8 bits sampled from the data input, placed according to the bit order.
- R7: The completion output is high for exactly one cycle per transfer. In internal-clock mode it is high in the same cycle in which the clock output shows the final sampling edge.
- R8: In internal-clock mode the data output enable is low from the data write until the first output edge. After the final edge, the last bit is held for n+1 prescale-enable cycles and then the output floats. A data write during that hold turns the enable off in the next cycle.
- R9: In external-clock mode (control bit 0 set) the clock output enable is low and the data output is always enabled. Outside a transfer it drives the level of control bit 3.
- R10: In external-clock mode every further sampling edge after the eighth still shifts the register, without another completion pulse.
- R11: A data write during a transfer does not change the transfer or its received byte. It sets the sticky error flag (control bit 4 on read), which stays set until a control write with bit 4 set clears it.
- R12: Reading address 1 returns the four control fields in bits 3:0 and the error flag in bit 4. Reading address 2 returns the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_en | input | 1 | Prescaled clock enable that paces the internal divider |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 data, 1 control, 2 divider |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for bus_addr |
| sclk_i | input | 1 | Transfer clock from the pin (external mode) |
| sclk_o | output | 1 | Generated transfer clock |
| sclk_oe | output | 1 | Clock pin drive enable (high in internal mode) |
| sdi_i | input | 1 | Serial data input |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Serial data output drive enable |
| done_o | output | 1 | One-cycle transfer completion pulse |

## Verification
In internal-clock mode each clock edge is registered at the same edge as the state it causes. The bench samples at the falling system-clock edge, so an output edge and any shifted output bit are visible at the first sample after the divider wraps. The completion pulse is checked in that same sample. The hold release is checked exactly n+1 enable cycles after the final edge, and the next transfer edge exactly n+1 enable cycles after the previous one. In external-clock mode the pin clock passes through a two-stage synchronizer and an edge register, so results trail a pin edge by about three cycles. The bench therefore holds each pin half-period for six cycles and reads the data output and completion count only at the end of each half-period. Register reads are combinational and are sampled one time step after the address settles.

// File: rtl/ssx_pkg.sv
package ssx_pkg;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIV  = 2'd2
    } ssx_reg_e;

    // control register bit positions
    localparam int CB_EXT  = 0;
    localparam int CB_POL  = 1;
    localparam int CB_MSB  = 2;
    localparam int CB_IDLE = 3;
    localparam int CB_ERR  = 4;

endpackage

// File: rtl/ssx_divider.sv
module ssx_divider #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         wrap
);

    logic [W-1:0] cnt_d, cnt_q;

    assign wrap = run && tick && !clr && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !run) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/ssx_sync_edge.sv
module ssx_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_pin,
    input  logic data_pin,
    output logic data_s,
    output logic rise_o,
    output logic fall_o
);

    // bit 0 carries the pin clock, bit 1 the pin data
    logic [STAGES:0][1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = {data_pin, clk_pin};
        for (int i = 1; i <= STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1][0] && !pipe_q[STAGES][0];
    assign fall_o = !pipe_q[STAGES-1][0] && pipe_q[STAGES][0];
    assign data_s = pipe_q[STAGES][1];

endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
    import ssx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prescale_en,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic              sdo_oe,
    output logic              done_o
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] sr;
        logic [DIV_W-1:0]  div;
        logic              ext;
        logic              pol;
        logic              msb;
        logic              idle;
        logic              err;
        logic              busy;
        logic              hold;
        logic              sclk;
        logic              out_bit;
        logic              drv;
        logic              done;
        logic [CNT_W-1:0]  nsamp;
    } state_t;

    state_t q, d;

    logic wr_data, wr_ctrl, wr_div, start;
    logic wrap, sdi_s, pin_rise, pin_fall;
    logic head, in_bit, tog;
    logic drive_ev, sample_ev;

    assign wr_data = bus_wr && (bus_addr == REG_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == REG_CTRL);
    assign wr_div  = bus_wr && (bus_addr == REG_DIV);
    assign start   = wr_data && !q.busy;

    ssx_divider #(.W(DIV_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .run   (q.busy || q.hold),
        .tick  (prescale_en),
        .limit (q.div),
        .wrap  (wrap)
    );

    ssx_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_pin  (sclk_i),
        .data_pin (sdi_i),
        .data_s   (sdi_s),
        .rise_o   (pin_rise),
        .fall_o   (pin_fall)
    );

    // edge events: internal clock toggles on divider wrap while busy
    always_comb begin
        head   = q.msb ? q.sr[DATA_W-1] : q.sr[0];
        in_bit = q.ext ? sdi_s : sdi_i;
        tog    = !q.ext && q.busy && wrap;
        if (q.ext) begin
            drive_ev  = q.busy && (q.pol ? pin_rise : pin_fall);
            sample_ev = q.pol ? pin_fall : pin_rise;
        end else begin
            drive_ev  = tog && (q.sclk != q.pol);
            sample_ev = tog && (q.sclk == q.pol);
        end
    end

    always_comb begin
        d      = q;
        d.done = 1'b0;

        if (tog) d.sclk = !q.sclk;

        if (drive_ev) begin
            d.out_bit = head;
            d.drv     = 1'b1;
        end

        if (sample_ev) begin
            d.sr = q.msb ? {q.sr[DATA_W-2:0], in_bit} : {in_bit, q.sr[DATA_W-1:1]};
            if (q.busy) begin
                d.nsamp = q.nsamp + 1'b1;
                if (q.nsamp == LAST_BIT) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                    d.hold = !q.ext;
                    d.drv  = !q.ext;
                end
            end
        end

        if (q.hold && !q.busy && wrap) begin
            d.hold = 1'b0;
            d.drv  = 1'b0;
        end

        if (!q.busy) d.sclk = !q.pol;

        if (wr_ctrl) begin
            d.ext  = bus_wdata[CB_EXT];
            d.pol  = bus_wdata[CB_POL];
            d.msb  = bus_wdata[CB_MSB];
            d.idle = bus_wdata[CB_IDLE];
            if (bus_wdata[CB_ERR]) d.err = 1'b0;
        end

        if (wr_div) d.div = bus_wdata[DIV_W-1:0];

        if (wr_data) begin
            if (q.busy) begin
                d.err = 1'b1;
            end else begin
                d.sr    = bus_wdata;
                d.busy  = 1'b1;
                d.nsamp = '0;
                d.hold  = 1'b0;
                d.drv   = 1'b0;
                d.sclk  = !q.pol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_DATA: bus_rdata = q.sr;
            REG_CTRL: begin
                bus_rdata[CB_EXT]  = q.ext;
                bus_rdata[CB_POL]  = q.pol;
                bus_rdata[CB_MSB]  = q.msb;
                bus_rdata[CB_IDLE] = q.idle;
                bus_rdata[CB_ERR]  = q.err;
            end
            REG_DIV:  bus_rdata = DATA_W'(q.div);
            default:  bus_rdata = '0;
        endcase
    end

    assign sclk_o  = q.sclk;
    assign sclk_oe = !q.ext;
    assign sdo_oe  = q.ext || q.drv;
    assign sdo_o   = q.ext ? ((q.busy && q.drv) ? q.out_bit : q.idle) : q.out_bit;
    assign done_o  = q.done;

    // R2: an idle data write launches a transfer
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !q.busy) |=> q.busy);

    // R7: completion lasts one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: completion only once the transfer has ended
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !q.busy);

    // R11: a write during a transfer raises the sticky flag
    p_busy_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && q.busy) |=> q.err);

    // R11: the flag stays until a clearing control write
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !(wr_ctrl && bus_wdata[CB_ERR])) |=> q.err);

    // R8: end of the hold window releases the data pin
    p_hold_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.ext && q.hold && wrap && !wr_data && !wr_ctrl) |=> !sdo_oe);

endmodule

// File: tb/test_sync_serial_xcvr.sv
module test_sync_serial_xcvr;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       prescale_en;
    logic       bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       sclk_i, sclk_o, sclk_oe;
    logic       sdi_i, sdo_o, sdo_oe, done_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  slow   = 1'b0;
    logic tick_ph = 1'b0;

    always #10 clk = ~clk;

    always @(negedge clk) tick_ph <= ~tick_ph;
    assign prescale_en = slow ? tick_ph : 1'b1;

    sync_serial_xcvr i_sync_serial_xcvr (
        .clk         (clk),
        .rst_n       (rst_n),
        .prescale_en (prescale_en),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sclk_i      (sclk_i),
        .sclk_o      (sclk_o),
        .sclk_oe     (sclk_oe),
        .sdi_i       (sdi_i),
        .sdo_o       (sdo_o),
        .sdo_oe      (sdo_oe),
        .done_o      (done_o)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit bit_at(logic [7:0] b, int k, bit msb);
        return msb ? b[7-k] : b[k];
    endfunction

    function automatic logic [7:0] shift_in(logic [7:0] b, bit x, bit msb);
        return msb ? {b[6:0], x} : {x, b[7:1]};
    endfunction

    function automatic logic [7:0] ctrl_byte(bit ext, bit pol, bit msb, bit idle, bit clr);
        return {3'b000, clr, idle, msb, pol, ext};
    endfunction

    task automatic bus_write(input logic [1:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // internally clocked transfer with a bench-side partner on the data pins
    task automatic run_int(input logic [7:0] tx, input logic [7:0] slave, input int dv,
                           input bit pol, input bit msb, input bit inject, input bit use_slow);
        int hp, edges, last, cyc, inj, n;
        logic prev;
        logic [7:0] v;
        hp = (dv + 1) * (use_slow ? 2 : 1);
        bus_write(2'd1, ctrl_byte(0, pol, msb, 0, 0));
        bus_write(2'd2, 8'(dv));
        slow = use_slow;
        sdi_i = 1'b0;
        @(negedge clk);
        chk(sclk_o == !pol, "R2 idle clock level", sclk_o, !pol);
        prev = sclk_o;
        bus_write(2'd0, tx);
        chk(sdo_oe == 1'b0, "R8 output floats before first edge", sdo_oe, 0);
        edges = 0; last = 0; cyc = 0; inj = 0;
        while (edges < 16 && cyc < 20000) begin
            @(negedge clk);
            cyc++;
            if (inj == 1) begin bus_wr = 1'b0; inj = 2; end
            if (inject && inj == 0 && edges == 5) begin
                bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = ~tx; inj = 1;
            end
            if (sclk_o != prev) begin
                edges++;
                if (edges > 1) chk(cyc - last == hp, "R3 half period", cyc - last, hp);
                last = cyc;
                prev = sclk_o;
                if (edges % 2 == 1) begin
                    chk(sclk_o == pol, "R5 output edge direction", sclk_o, pol);
                    chk(sdo_oe == 1'b1, "R8 output driven", sdo_oe, 1);
                    chk(sdo_o == bit_at(tx, (edges-1)/2, msb), "R4 R5 transmit bit",
                        sdo_o, bit_at(tx, (edges-1)/2, msb));
                    sdi_i = bit_at(slave, (edges-1)/2, msb);
                end else begin
                    chk(done_o == (edges == 16), "R7 completion at final edge", done_o, edges == 16);
                end
            end else if (done_o) begin
                chk(1'b0, "R7 completion off edge", 1, 0);
            end
        end
        bus_wr = 1'b0;
        chk(edges == 16, "R2 pulse count", edges, 16);
        chk(sclk_o == !pol, "R2 rest level after transfer", sclk_o, !pol);
        chk(sdo_oe && sdo_o == bit_at(tx, 7, msb), "R8 last bit held", sdo_o, bit_at(tx, 7, msb));
        n = 0;
        while (sdo_oe && n < 3000) begin
            @(negedge clk);
            n++;
            if (done_o) chk(1'b0, "R7 second completion", 1, 0);
        end
        chk(n == hp, "R8 hold length", n, hp);
        chk(sclk_o == !pol, "R2 no further pulses", sclk_o, !pol);
        bus_read(2'd0, v);
        chk(v == slave, "R6 received byte", v, slave);
        if (inject) begin
            bus_read(2'd1, v);
            chk(v[4] == 1'b1, "R11 error flag set", v[4], 1);
            bus_write(2'd1, ctrl_byte(0, pol, msb, 0, 1));
            bus_read(2'd1, v);
            chk(v[4] == 1'b0, "R11 error flag cleared", v[4], 0);
        end
        slow = 1'b0;
    endtask

    // externally clocked transfer, bench drives the pin clock
    task automatic run_ext(input logic [7:0] tx, input logic [7:0] slave, input bit pol,
                           input bit msb, input bit idle, input bit extra);
        int dn;
        logic [7:0] v;
        sclk_i = !pol;
        bus_write(2'd1, ctrl_byte(1, pol, msb, idle, 0));
        repeat (4) @(negedge clk);
        chk(sdo_oe == 1'b1 && sdo_o == idle, "R9 rest level driven", sdo_o, idle);
        chk(sclk_oe == 1'b0, "R9 clock pin is input", sclk_oe, 0);
        bus_write(2'd0, tx);
        dn = 0;
        for (int k = 0; k < 8; k++) begin
            sclk_i = pol;
            sdi_i  = bit_at(slave, k, msb);
            repeat (6) begin @(negedge clk); if (done_o) dn++; end
            chk(sdo_o == bit_at(tx, k, msb), "R4 R5 external transmit bit", sdo_o, bit_at(tx, k, msb));
            sclk_i = !pol;
            repeat (6) begin @(negedge clk); if (done_o) dn++; end
        end
        chk(dn == 1, "R7 one completion", dn, 1);
        chk(sdo_oe == 1'b1 && sdo_o == idle, "R9 rest level after transfer", sdo_o, idle);
        bus_read(2'd0, v);
        chk(v == slave, "R6 external received byte", v, slave);
        if (extra) begin
            dn = 0;
            sclk_i = pol;
            sdi_i  = !slave[0];
            repeat (6) begin @(negedge clk); if (done_o) dn++; end
            sclk_i = !pol;
            repeat (6) begin @(negedge clk); if (done_o) dn++; end
            bus_read(2'd0, v);
            chk(v == shift_in(slave, !slave[0], msb), "R10 extra edge shifts",
                v, shift_in(slave, !slave[0], msb));
            chk(dn == 0, "R10 no extra completion", dn, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        int n;
        void'($urandom(32'h5eed));
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = 8'h00;
        sclk_i = 1'b1; sdi_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sdo_oe == 1'b0, "R1 data output floats", sdo_oe, 0);
        chk(sclk_o == 1'b1 && sclk_oe == 1'b1, "R1 clock pin", {sclk_o, sclk_oe}, 3);
        chk(done_o == 1'b0, "R1 completion low", done_o, 0);
        bus_read(2'd0, v);
        chk(v == 8'h00, "R1 data register", v, 0);
        bus_read(2'd1, v);
        chk(v == 8'h00, "R1 control register", v, 0);

        bus_write(2'd2, 8'hA5);
        bus_read(2'd2, v);
        chk(v == 8'hA5, "R12 divider readback", v, 8'hA5);
        bus_write(2'd1, 8'h0E);
        bus_read(2'd1, v);
        chk(v == 8'h0E, "R12 control readback", v, 8'h0E);
        bus_write(2'd1, 8'h00);

        run_int(8'h3C, 8'hA6, 0,   0, 0, 0, 0);
        run_int(8'h81, 8'h5B, 3,   1, 1, 0, 0);
        run_int(8'hF0, 8'h0F, 255, 0, 1, 0, 0);
        run_int(8'h96, 8'h69, 2,   1, 0, 0, 1);
        run_int(8'hC3, 8'h3A, 4,   0, 1, 1, 0);

        // R8: a data write inside the hold window releases the pin at once
        bus_write(2'd1, ctrl_byte(0, 0, 0, 0, 0));
        bus_write(2'd2, 8'd6);
        bus_write(2'd0, 8'h55);
        n = 0;
        while (!done_o && n < 3000) begin @(negedge clk); n++; end
        chk(sdo_oe == 1'b1, "R8 hold active", sdo_oe, 1);
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'hAA;
        @(negedge clk);
        bus_wr = 1'b0;
        chk(sdo_oe == 1'b0, "R8 hold cut by write", sdo_oe, 0);
        n = 0;
        while (!done_o && n < 3000) begin @(negedge clk); n++; end
        repeat (20) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            run_int(8'($urandom), 8'($urandom), $urandom_range(0, 9),
                    1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0), 1'($urandom));
        end

        run_ext(8'hB2, 8'h4D, 0, 0, 1, 1);
        run_ext(8'h1E, 8'hE1, 1, 1, 0, 1);
        for (int i = 0; i < 4; i++) begin
            run_ext(8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end

        summary();
        $finish;
    end

endmodule